// File: doc/BRIEF.md
# Transmit Slot and Bit Delay Retimer

This block sits in the transmit path of a time-division ground station. It moves an outgoing byte from the slot where the station's local timing produces it into a later slot. The station's burst then reaches the relay at the right place in the network frame. A whole-slot (coarse) shift is set by a replay-slot selector. A sub-slot (fine) shift of 0 to 7 bit periods follows it.

Timing comes from free-running bit, slot and frame counters. Each slot has 8 bits, each frame has 32 slots, and a superframe has 256 frames. The counters start from zero at reset and are realigned by a one-cycle sync strobe. Two replay lanes share the serial input:
- The data lane captures slot (N+16) mod 32 of every frame and replays the byte in slot (N+N'') mod 32.
- The signalling lane captures slot 16 of frame 0 only and replays it once, in slot N''.

Each lane loads its capture byte into a replay shifter at the start of the replay slot. The shifter fills with zeros behind the outgoing bits. The coarse delay is D = (N''−16) mod 32 slots. Selector values that put capture and replay in the same slot or in adjacent slots are unsafe, so those values mute the output.

Top module: `txSlotRetimer`

## Requirements
- R1: At reset the bit, slot and frame counters are zero and txOut is 0. When syncIn is high at a clock edge, the next cycle is bit 0 of slot 0 of frame 0. A slot lasts 8 cycles, a frame 32 slots and a superframe 256 frames.
- R2: The data lane samples txIn during the 8 cycles of slot (dataSlot+16) mod 32 of every frame. The bit sampled in cycle b of that slot is bit b of the byte, and bit 0 is sent first.
- R3: With fineSel=0 and D=(replaySel−16) mod 32, the bit sampled in cycle c of the capture slot appears on txOut in cycle c+8·D+1. The replayed byte is the one most recently captured, or all zeros if nothing has been captured since reset.
- R4: Values on txIn outside the capture slots have no effect on txOut.
- R5: fineSel adds a further delay of fineSel cycles (0 to 7) to every replayed bit.
- R6: The signalling lane samples only slot 16 of frame 0. It replays that byte once, D slots later (in slot replaySel), with the same timing as R3. Slot 16 of any other frame is not captured.
- R7: txOut is 0 in every cycle that carries no replayed bit. When both lanes replay in the same slot, their bits are ORed.
- R8: When replaySel is 15, 16 or 17, txOut stays 0 whatever the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Realigns the counters; the next cycle is bit 0, slot 0, frame 0 |
| txIn | input | 1 | Serial data and signalling from the local framer |
| dataSlot | input | 5 | Data slot index N |
| replaySel | input | 5 | Replay slot selector N'' |
| fineSel | input | 3 | Fine delay in bit periods |
| txOut | output | 1 | Retimed serial output |

## Verification
The signalling lane is the hardest to reach. It captures only once per superframe, in frame 0, and then replays only once. A run must therefore start from a fresh counter alignment and continue past frame 1, so that the missing replay of a second frame is also seen. Each scenario releases reset or pulses syncIn to fix frame 0, and then drives a distinct signalling byte, a data byte and noise in all other slots. For every cycle, a reference computed from the slot arithmetic predicts txOut, including slot wrap across frames and the three muted selector values.

// File: rtl/txRetimePkg.sv
package txRetimePkg;
  // strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic dataCap;
    logic dataLoad;
    logic dataShift;
    logic sigCap;
    logic sigLoad;
    logic sigShift;
    logic mute;
  } retimeStrobe_t;
endpackage

// File: rtl/replayLane.sv
module replayLane #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic serIn,
  input  logic capEn,
  input  logic loadEn,
  input  logic shiftEn,
  output logic outBit
);
  logic [WIDTH-1:0] capReg;
  logic [WIDTH-1:0] playReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReg  <= '0;
      playReg <= '0;
      outBit  <= 1'b0;
    end else begin
      if (capEn) capReg <= {serIn, capReg[WIDTH-1:1]};
      if (loadEn) begin
        outBit  <= capReg[0];
        playReg <= {1'b0, capReg[WIDTH-1:1]};
      end else if (shiftEn) begin
        outBit  <= playReg[0];
        playReg <= {1'b0, playReg[WIDTH-1:1]};
      end else begin
        outBit  <= 1'b0;
      end
    end
  end

  // R7: a lane with no replay strobe drives nothing in the next cycle
  assert_lane_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !shiftEn) |=> !outBit);
endmodule

// File: rtl/retimeCtl.sv
module retimeCtl
  import txRetimePkg::*;
#(
  parameter int BIT_W    = 3,
  parameter int SLOT_W   = 5,
  parameter int FRAME_W  = 8,
  parameter int SIG_SLOT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic [SLOT_W-1:0] dataSlot,
  input  logic [SLOT_W-1:0] replaySel,
  output retimeStrobe_t     str
);
  localparam logic [SLOT_W-1:0] SLOT_HALF = SLOT_W'(1 << (SLOT_W - 1));
  localparam logic [BIT_W-1:0]  LAST_BIT  = '1;
  localparam logic [SLOT_W-1:0] SIG_IDX   = SLOT_W'(SIG_SLOT);

  logic [BIT_W-1:0]   bitCnt;
  logic [SLOT_W-1:0]  slotCnt;
  logic [FRAME_W-1:0] frameCnt;
  logic               sigPending;
  logic               sigActive;

  logic [SLOT_W-1:0] capSlot;
  logic [SLOT_W-1:0] repSlot;
  logic [SLOT_W-1:0] coarse;
  logic              sigWindow;
  logic              lastBit;

  always_comb begin
    capSlot   = dataSlot + SLOT_HALF;
    repSlot   = dataSlot + replaySel;
    coarse    = replaySel - SLOT_HALF;
    sigWindow = (slotCnt == SIG_IDX) && (frameCnt == '0);
    lastBit   = (bitCnt == LAST_BIT);

    str.mute      = (coarse == '0) || (coarse == SLOT_W'(1)) || (coarse == '1);
    str.dataCap   = (slotCnt == capSlot);
    str.dataLoad  = (slotCnt == repSlot) && (bitCnt == '0);
    str.dataShift = (slotCnt == repSlot) && (bitCnt != '0);
    str.sigCap    = sigWindow;
    str.sigLoad   = (slotCnt == replaySel) && (bitCnt == '0) && sigPending;
    str.sigShift  = sigActive && (bitCnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN || syncIn) begin
      bitCnt   <= '0;
      slotCnt  <= '0;
      frameCnt <= '0;
    end else begin
      bitCnt <= bitCnt + BIT_W'(1);
      if (lastBit) begin
        slotCnt <= slotCnt + SLOT_W'(1);
        if (slotCnt == '1) frameCnt <= frameCnt + FRAME_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sigPending <= 1'b0;
      sigActive  <= 1'b0;
    end else begin
      if (sigWindow && lastBit) sigPending <= 1'b1;
      else if (str.sigLoad)     sigPending <= 1'b0;
      if (str.sigLoad)  sigActive <= 1'b1;
      else if (lastBit) sigActive <= 1'b0;
    end
  end

  // R1: sync realigns all counters to the start of a superframe
  assert_sync_align_R1: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> (bitCnt == '0 && slotCnt == '0 && frameCnt == '0));

  // R1: a slot ends after its last bit
  assert_slot_advance_R1: assert property (@(posedge clk) disable iff (!rstN)
    (lastBit && !syncIn) |=> (bitCnt == '0 && slotCnt == $past(slotCnt) + SLOT_W'(1)));

  // R6: a signalling replay consumes its pending byte
  assert_sig_once_R6: assert property (@(posedge clk) disable iff (!rstN)
    str.sigLoad |=> !sigPending);
endmodule

// File: rtl/retimePath.sv
module retimePath
  import txRetimePkg::*;
#(
  parameter int BIT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txIn,
  input  retimeStrobe_t    str,
  input  logic [BIT_W-1:0] fineSel,
  output logic             txOut
);
  localparam int WIDTH = 1 << BIT_W;
  localparam int DEPTH = WIDTH - 1;
  localparam int LANES = 2;

  logic [LANES-1:0] laneCap, laneLoad, laneShift, laneOut;
  logic             stream;
  logic [DEPTH-1:0] fineLine;
  logic [WIDTH-1:0] taps;

  assign laneCap   = {str.sigCap,   str.dataCap};
  assign laneLoad  = {str.sigLoad,  str.dataLoad};
  assign laneShift = {str.sigShift, str.dataShift};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    replayLane #(.WIDTH(WIDTH)) uLane (
      .clk    (clk),
      .rstN   (rstN),
      .serIn  (txIn),
      .capEn  (laneCap[g]),
      .loadEn (laneLoad[g]),
      .shiftEn(laneShift[g]),
      .outBit (laneOut[g])
    );
  end

  assign stream = |laneOut;

  always_ff @(posedge clk) begin
    if (!rstN) fineLine <= '0;
    else       fineLine <= {fineLine[DEPTH-2:0], stream};
  end

  assign taps[0] = stream;
  for (genvar t = 1; t < WIDTH; t++) begin : gTap
    assign taps[t] = fineLine[t-1];
  end

  assign txOut = str.mute ? 1'b0 : taps[fineSel];

  // R7: the merged stream is quiet after a cycle with no replay strobe
  assert_stream_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(str.dataLoad || str.dataShift || str.sigLoad || str.sigShift) |-> !stream);
endmodule

// File: rtl/txSlotRetimer.sv
module txSlotRetimer
  import txRetimePkg::*;
#(
  parameter int BIT_W    = 3,
  parameter int SLOT_W   = 5,
  parameter int FRAME_W  = 8,
  parameter int SIG_SLOT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic              txIn,
  input  logic [SLOT_W-1:0] dataSlot,
  input  logic [SLOT_W-1:0] replaySel,
  input  logic [BIT_W-1:0]  fineSel,
  output logic              txOut
);
  retimeStrobe_t ctlStr;

  retimeCtl #(
    .BIT_W(BIT_W), .SLOT_W(SLOT_W), .FRAME_W(FRAME_W), .SIG_SLOT(SIG_SLOT)
  ) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .syncIn   (syncIn),
    .dataSlot (dataSlot),
    .replaySel(replaySel),
    .str      (ctlStr)
  );

  retimePath #(.BIT_W(BIT_W)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .txIn   (txIn),
    .str    (ctlStr),
    .fineSel(fineSel),
    .txOut  (txOut)
  );
endmodule

// File: tb/sim_txSlotRetimer.sv
module sim_txSlotRetimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncIn = 1'b0;
  logic       txIn = 1'b0;
  logic [4:0] dataSlot = '0;
  logic [4:0] replaySel = '0;
  logic [2:0] fineSel = '0;
  logic       txOut;

  int checks = 0;
  int errors = 0;
  int cfgN, cfgNpp, cfgFine;
  logic [7:0] dByte, sByte;

  always #2 clk = ~clk;

  txSlotRetimer u0 (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .txIn(txIn),
    .dataSlot(dataSlot), .replaySel(replaySel), .fineSel(fineSel), .txOut(txOut)
  );

  // stimulus for cycle n after alignment: signalling, data byte or noise
  function automatic logic inBit(int n);
    int b = n % 8;
    int s = (n / 8) % 32;
    int f = (n / 256) % 256;
    if (s == 16 && f == 0) return sByte[b];
    if (s == (cfgN + 16) % 32) return dByte[b];
    return ((n * 5) % 7) < 3;
  endfunction

  // expected txOut for cycle m, from the requirements
  function automatic logic refOut(int m);
    int d = (cfgNpp + 16) % 32;
    int k, s, j;
    logic r = 1'b0;
    if (d == 0 || d == 1 || d == 31) return 1'b0;   // R8
    k = m - 1 - cfgFine;                             // R3 latency, R5 fine
    if (k < 0) return 1'b0;
    s = (k / 8) % 32;
    j = k - 8 * d;
    if (j < 0) return 1'b0;
    if (s == (cfgN + cfgNpp) % 32) r = r | inBit(j);                  // R2 R3
    if (s == cfgNpp && ((j / 256) % 256) == 0) r = r | inBit(j);      // R6
    return r;
  endfunction

  task automatic checkBit(string tag, int n, logic exp);
    checks++;
    if (txOut !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d txOut=%b expected %b", tag, n, txOut, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    syncIn = 1'b0;
    txIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // one scenario: align, drive every cycle, compare every cycle
  task automatic runCase(string tag, int n, int npp, int fine,
                         logic [7:0] d, logic [7:0] s, int cycles, int pre);
    cfgN = n; cfgNpp = npp; cfgFine = fine; dByte = d; sByte = s;
    dataSlot = 5'(n); replaySel = 5'(npp); fineSel = 3'(fine);
    applyReset();
    rstN = 1'b1;
    if (pre > 0) begin
      for (int p = 0; p < pre; p++) begin
        txIn = 1'b0;
        checkBit({tag, " pre-sync R1"}, p, 1'b0);
        @(negedge clk);
      end
      syncIn = 1'b1;
      @(negedge clk);
      syncIn = 1'b0;
    end
    for (int c = 0; c < cycles; c++) begin
      txIn = inBit(c);
      checkBit(tag, c, refOut(c));
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    applyReset();
    checkBit("R1 reset", 0, 1'b0);
  endtask

  task automatic testBasic();      // R2 R3 R4 R7: D=4, no wrap
    runCase("R2 R3 R4 R7 basic", 3, 20, 0, 8'hB4, 8'h00, 600, 0);
  endtask

  task automatic testWrap();       // R3: replay slot before capture slot
    runCase("R3 wrap", 10, 5, 0, 8'h6D, 8'h00, 700, 0);
  endtask

  task automatic testFine();       // R5
    runCase("R5 fine5", 3, 20, 5, 8'hC9, 8'h00, 600, 0);
    runCase("R5 fine7", 7, 30, 7, 8'h81, 8'h00, 600, 0);
  endtask

  task automatic testSignal();     // R6 R7: replay only once, frame 1 quiet
    runCase("R6 signalling", 2, 24, 2, 8'h3C, 8'hA5, 800, 0);
    runCase("R6 R7 shared slot", 0, 20, 0, 8'h5A, 8'hE7, 800, 0);
  endtask

  task automatic testConflict();   // R8
    runCase("R8 zero", 3, 16, 0, 8'hFF, 8'hFF, 400, 0);
    runCase("R8 minus", 3, 15, 3, 8'hFF, 8'hFF, 400, 0);
    runCase("R8 plus", 3, 17, 0, 8'hFF, 8'hFF, 400, 0);
  endtask

  task automatic testSync();       // R1
    runCase("R1 sync", 4, 25, 1, 8'h97, 8'h4E, 600, 37);
  endtask

  initial begin
    testReset();
    testBasic();
    testWrap();
    testFine();
    testSignal();
    testConflict();
    testSync();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #700000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule